// File: doc/BRIEF.md
# Rotational-Interleaving Bank Placement Unit

Each tile of a tiled last-level cache holds one copy of this unit. It receives a memory request together with the class of the page it belongs to, and decides which tile's cache bank must serve the request. Private-data requests stay in the requesting tile. Shared-data requests go to a fixed home bank, picked by a slice of the address.

Instruction requests are spread over a small cluster of four neighbouring tiles. The tiles are numbered with a 2-bit rotational id that rises by one from left to right along a row and shifts by two from one row to the next. Two address bits just above the set index form a selector. The modulo-4 difference between the tile's rotational id and that selector picks one of four targets: the tile itself, its left neighbour, its right neighbour, or the tile below it. Every tile in a cluster therefore sends a given selector value to the same bank.

If that cluster bank reports a miss, the unit issues a second lookup to the static home bank of the address. The destination leaves the unit through a valid/ready handshake, together with an attempt number: 0 for the first lookup and 1 for the fallback. The mesh is 4x4. When a neighbour is computed, the columns and rows wrap around.

Top module: `rip_placement_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `dst_valid` is 0. `req_ready` and `dst_valid` are never 1 in the same cycle.
- R2: A request of class 0 (private data) produces one destination equal to the requesting tile's own `tile_x`/`tile_y`, with attempt 0. After that destination is accepted, the unit is ready again.
- R3: A request of class 1 (shared data) produces one destination with attempt 0. Its x is address bits [17:16] and its y is address bits [19:18].
- R4: A request of class 2 (instruction) takes A = address bits [15:14] and computes D = (rid - A) mod 4. D=0 targets the tile itself, D=3 targets x+1, D=1 targets x-1, and D=2 targets y+1. The attempt is 0.
- R5: The neighbour coordinates in R4 wrap around: x+1 from column 3 gives column 0, x-1 from column 0 gives column 3, and y+1 from row 3 gives row 0.
- R6: While `dst_valid` is 1 and `dst_ready` is 0, `dst_valid`, `dst_x`, `dst_y` and `dst_attempt` hold their values.
- R7: After an instruction destination is accepted, the unit waits for `rsp_valid`. A response with `rsp_hit`=1 returns the unit to ready and produces no further destination.
- R8: A response with `rsp_hit`=0 to an instruction lookup produces, on the next cycle, a destination equal to the R3 home bank of the same address, with attempt 1. The unit is ready again once that destination is accepted.
- R9: `rsp_valid` has no effect while the unit is not waiting for a response. In particular, a miss pulse while idle produces no destination.
- R10: Class code 3 is handled exactly like class 1 (shared data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tile_x | input | 2 | Column of this tile |
| tile_y | input | 2 | Row of this tile |
| tile_rid | input | 2 | Rotational id of this tile |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | 32 | Request block address |
| req_cls | input | 2 | Page class: 0 private, 1 shared, 2 instruction, 3 treated as shared |
| dst_valid | output | 1 | Destination present |
| dst_ready | input | 1 | Destination taken by the network |
| dst_x | output | 2 | Destination column |
| dst_y | output | 2 | Destination row |
| dst_attempt | output | 1 | 0 for the first lookup, 1 for the fallback |
| rsp_valid | input | 1 | Lookup response from the cluster bank |
| rsp_hit | input | 1 | Response was a hit |

## Verification
A wrong hop decode or a missing wrap shows up as a bad `dst_x`/`dst_y` in the first cycle the destination is valid, one clock after the request is accepted. A sequencer stuck in the wrong state shows up as `req_ready` and `dst_valid` disagreeing with the expected phase, within one cycle of the handshake or response that should have moved it. A fallback sent to the wrong bank, or carrying the wrong attempt number, is visible one cycle after the miss response. The reference model predicts both handshake signals and the destination fields on every clock, so any of these faults is caught in the cycle it first appears.

// File: rtl/rip_pkg.sv
package rip_pkg;

  // Page class codes carried with each request
  typedef enum logic [1:0] {
    PG_PRIV   = 2'd0,
    PG_SHARED = 2'd1,
    PG_INSTR  = 2'd2,
    PG_RSVD   = 2'd3
  } page_cls_e;

  // Hop selected by (rid - A) mod 4
  typedef enum logic [1:0] {
    HOP_SELF  = 2'd0,
    HOP_LEFT  = 2'd1,
    HOP_DOWN  = 2'd2,
    HOP_RIGHT = 2'd3
  } hop_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FIRST = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_FALL  = 2'd3
  } seq_state_e;

  // Step a coordinate by delta on a ring of n positions
  function automatic int unsigned ring_step(input int unsigned v,
                                            input int signed delta,
                                            input int unsigned n);
    int signed s;
    s = int'(v) + delta + int'(n);
    return int'(s) % n;
  endfunction

  // Rotational hop from tile id and address selector
  function automatic hop_e hop_of(input logic [1:0] rid, input logic [1:0] sel);
    logic [1:0] d;
    d = rid - sel;
    return hop_e'(d);
  endfunction

endpackage

// File: rtl/rip_cluster_pick.sv
module rip_cluster_pick
  import rip_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  localparam int X_W = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int Y_W = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic [X_W-1:0] self_x,
  input  logic [Y_W-1:0] self_y,
  input  logic [1:0]     rid,
  input  logic [1:0]     sel,
  output hop_e           hop,
  output logic [X_W-1:0] pick_x,
  output logic [Y_W-1:0] pick_y
);

  logic [X_W-1:0] right_x, left_x;
  logic [Y_W-1:0] down_y;

  assign hop     = hop_of(rid, sel);
  assign right_x = X_W'(ring_step(int'(self_x), 1, MESH_X));
  assign left_x  = X_W'(ring_step(int'(self_x), -1, MESH_X));
  assign down_y  = Y_W'(ring_step(int'(self_y), 1, MESH_Y));

  always_comb begin
    pick_x = self_x;
    pick_y = self_y;
    unique case (hop)
      HOP_SELF:  ;
      HOP_LEFT:  pick_x = left_x;
      HOP_RIGHT: pick_x = right_x;
      HOP_DOWN:  pick_y = down_y;
    endcase
  end

endmodule

// File: rtl/rip_home_map.sv
module rip_home_map #(
  parameter int ADDR_W   = 32,
  parameter int HOME_LSB = 16,
  parameter int MESH_X   = 4,
  parameter int MESH_Y   = 4,
  localparam int X_W = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int Y_W = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [X_W-1:0]    home_x,
  output logic [Y_W-1:0]    home_y
);

  logic [X_W-1:0] raw_x;
  logic [Y_W-1:0] raw_y;

  assign raw_x = addr[HOME_LSB +: X_W];
  assign raw_y = addr[HOME_LSB + X_W +: Y_W];

  generate
    if ((1 << X_W) == MESH_X) begin : g_x_pow2
      assign home_x = raw_x;
    end else begin : g_x_fold
      assign home_x = X_W'(int'(raw_x) % MESH_X);
    end
    if ((1 << Y_W) == MESH_Y) begin : g_y_pow2
      assign home_y = raw_y;
    end else begin : g_y_fold
      assign home_y = Y_W'(int'(raw_y) % MESH_Y);
    end
  endgenerate

endmodule

// File: rtl/rip_seq.sv
module rip_seq
  import rip_pkg::*;
#(
  parameter int X_W = 2,
  parameter int Y_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_is_instr,
  input  logic [X_W-1:0] first_x,
  input  logic [Y_W-1:0] first_y,
  input  logic [X_W-1:0] home_x,
  input  logic [Y_W-1:0] home_y,
  output logic           dst_valid,
  input  logic           dst_ready,
  output logic [X_W-1:0] dst_x,
  output logic [Y_W-1:0] dst_y,
  output logic           dst_attempt,
  input  logic           rsp_valid,
  input  logic           rsp_hit,
  output logic           accept_evt,
  output logic           send_evt,
  output logic           hit_evt,
  output logic           miss_evt
);

  seq_state_e     state_q;
  logic           instr_q;
  logic [X_W-1:0] cur_x_q, fb_x_q;
  logic [Y_W-1:0] cur_y_q, fb_y_q;

  assign req_ready   = (state_q == SQ_IDLE);
  assign dst_valid   = (state_q == SQ_FIRST) || (state_q == SQ_FALL);
  assign dst_attempt = (state_q == SQ_FALL);
  assign dst_x       = cur_x_q;
  assign dst_y       = cur_y_q;

  assign accept_evt = req_valid && req_ready;
  assign send_evt   = dst_valid && dst_ready;
  assign hit_evt    = (state_q == SQ_WAIT) && rsp_valid && rsp_hit;
  assign miss_evt   = (state_q == SQ_WAIT) && rsp_valid && !rsp_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      instr_q <= 1'b0;
      cur_x_q <= '0;
      cur_y_q <= '0;
      fb_x_q  <= '0;
      fb_y_q  <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (accept_evt) begin
          state_q <= SQ_FIRST;
          instr_q <= req_is_instr;
          cur_x_q <= first_x;
          cur_y_q <= first_y;
          fb_x_q  <= home_x;
          fb_y_q  <= home_y;
        end
        SQ_FIRST: if (send_evt) begin
          state_q <= instr_q ? SQ_WAIT : SQ_IDLE;
        end
        SQ_WAIT: begin
          if (hit_evt) begin
            state_q <= SQ_IDLE;
          end else if (miss_evt) begin
            state_q <= SQ_FALL;
            cur_x_q <= fb_x_q;
            cur_y_q <= fb_y_q;
          end
        end
        SQ_FALL: if (send_evt) begin
          state_q <= SQ_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/rip_placement_unit.sv
module rip_placement_unit
  import rip_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 6,
  parameter int SET_W  = 8,
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  localparam int SEL_LSB  = OFS_W + SET_W,
  localparam int HOME_LSB = SEL_LSB + 2,
  localparam int X_W = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int Y_W = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [X_W-1:0]    tile_x,
  input  logic [Y_W-1:0]    tile_y,
  input  logic [1:0]        tile_rid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_cls,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [X_W-1:0]    dst_x,
  output logic [Y_W-1:0]    dst_y,
  output logic              dst_attempt,
  input  logic              rsp_valid,
  input  logic              rsp_hit
);

  page_cls_e      cls;
  hop_e           hop;
  logic [1:0]     sel;
  logic [X_W-1:0] clu_x, home_x, first_x;
  logic [Y_W-1:0] clu_y, home_y, first_y;
  logic           is_instr;
  logic           accept_evt, send_evt, hit_evt, miss_evt;

  assign cls      = page_cls_e'(req_cls);
  assign sel      = req_addr[SEL_LSB +: 2];
  assign is_instr = (cls == PG_INSTR);

  rip_cluster_pick #(.MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_pick (
    .self_x (tile_x),
    .self_y (tile_y),
    .rid    (tile_rid),
    .sel    (sel),
    .hop    (hop),
    .pick_x (clu_x),
    .pick_y (clu_y)
  );

  rip_home_map #(.ADDR_W(ADDR_W), .HOME_LSB(HOME_LSB),
                 .MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_home (
    .addr   (req_addr),
    .home_x (home_x),
    .home_y (home_y)
  );

  always_comb begin
    unique case (cls)
      PG_PRIV:  begin first_x = tile_x; first_y = tile_y; end
      PG_INSTR: begin first_x = clu_x;  first_y = clu_y;  end
      default:  begin first_x = home_x; first_y = home_y; end
    endcase
  end

  rip_seq #(.X_W(X_W), .Y_W(Y_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_is_instr (is_instr),
    .first_x      (first_x),
    .first_y      (first_y),
    .home_x       (home_x),
    .home_y       (home_y),
    .dst_valid    (dst_valid),
    .dst_ready    (dst_ready),
    .dst_x        (dst_x),
    .dst_y        (dst_y),
    .dst_attempt  (dst_attempt),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .accept_evt   (accept_evt),
    .send_evt     (send_evt),
    .hit_evt      (hit_evt),
    .miss_evt     (miss_evt)
  );

endmodule

// File: rtl/rip_placement_chk.sv
module rip_placement_chk #(
  parameter int X_W = 2,
  parameter int Y_W = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [X_W-1:0] tile_x,
  input logic [Y_W-1:0] tile_y,
  input logic           req_valid,
  input logic           req_ready,
  input logic [1:0]     req_cls,
  input logic           dst_valid,
  input logic           dst_ready,
  input logic [X_W-1:0] dst_x,
  input logic [Y_W-1:0] dst_y,
  input logic           dst_attempt,
  input logic           rsp_valid,
  input logic           accept_evt,
  input logic           hit_evt,
  input logic           miss_evt
);

  // R1
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && dst_valid));

  // R2
  private_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && req_cls == 2'd0 |=>
      dst_valid && dst_x == $past(tile_x) && dst_y == $past(tile_y) && !dst_attempt);

  // R6
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready |=>
      dst_valid && $stable(dst_x) && $stable(dst_y) && $stable(dst_attempt));

  // R7
  hit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> req_ready && !dst_valid);

  // R8
  miss_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> dst_valid && dst_attempt);

  // R9
  idle_rsp_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && rsp_valid && !req_valid |=> req_ready && !dst_valid);

endmodule

bind rip_placement_unit rip_placement_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tile_x      (tile_x),
  .tile_y      (tile_y),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_cls     (req_cls),
  .dst_valid   (dst_valid),
  .dst_ready   (dst_ready),
  .dst_x       (dst_x),
  .dst_y       (dst_y),
  .dst_attempt (dst_attempt),
  .rsp_valid   (rsp_valid),
  .accept_evt  (accept_evt),
  .hit_evt     (hit_evt),
  .miss_evt    (miss_evt)
);

// File: tb/tb_rip_placement_unit.sv
module tb_rip_placement_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tile_x = '0, tile_y = '0, tile_rid = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_cls = '0;
  logic        dst_valid;
  logic        dst_ready = 1'b0;
  logic [1:0]  dst_x, dst_y;
  logic        dst_attempt;
  logic        rsp_valid = 1'b0, rsp_hit = 1'b0;

  int vectors = 0;
  int misses  = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  rip_placement_unit dut (
    .clk(clk), .rst_n(rst_n), .tile_x(tile_x), .tile_y(tile_y),
    .tile_rid(tile_rid), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cls(req_cls), .dst_valid(dst_valid),
    .dst_ready(dst_ready), .dst_x(dst_x), .dst_y(dst_y),
    .dst_attempt(dst_attempt), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit)
  );

  // Reference model: phase 0 idle, 1 first send, 2 awaiting response, 3 fallback send
  int m_phase = 0;
  int m_x = 0, m_y = 0, m_att = 0, m_cls = 0;
  int m_hx = 0, m_hy = 0;

  function automatic int home_col(input logic [31:0] a); return (a >> 16) & 3; endfunction
  function automatic int home_row(input logic [31:0] a); return (a >> 18) & 3; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
    end else begin
      case (m_phase)
        0: if (req_valid) begin
          m_cls = req_cls;
          m_hx = home_col(req_addr);
          m_hy = home_row(req_addr);
          m_att = 0;
          if (m_cls == 0) begin
            m_x = tile_x; m_y = tile_y;
          end else if (m_cls == 2) begin
            int d;
            d = (int'(tile_rid) - int'((req_addr >> 14) & 3) + 8) % 4;
            m_x = tile_x; m_y = tile_y;
            if (d == 3) m_x = (tile_x + 1) % 4;
            else if (d == 1) m_x = (tile_x + 3) % 4;
            else if (d == 2) m_y = (tile_y + 1) % 4;
          end else begin
            m_x = m_hx; m_y = m_hy;
          end
          m_phase = 1;
        end
        1: if (dst_ready) m_phase = (m_cls == 2) ? 2 : 0;
        2: if (rsp_valid) begin
          if (rsp_hit) m_phase = 0;
          else begin m_phase = 3; m_x = m_hx; m_y = m_hy; m_att = 1; end
        end
        default: if (dst_ready) m_phase = 0;
      endcase
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("req_ready", req_ready, m_phase == 0);
      cmp("dst_valid", dst_valid, (m_phase == 1) || (m_phase == 3));
      if (m_phase == 1 || m_phase == 3) begin
        cmp("dst_x", dst_x, m_x);
        cmp("dst_y", dst_y, m_y);
        cmp("dst_attempt", dst_attempt, m_att);
      end
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  // One full transaction; stall = cycles dst_ready held low; hit chooses response
  task automatic run_req(input logic [31:0] a, input logic [1:0] c,
                         input int stall, input bit hit);
    req_addr = a; req_cls = c; req_valid = 1'b1;
    tick();
    req_valid = 1'b0; req_addr = $urandom;
    for (int i = 0; i < stall; i++) tick();
    dst_ready = 1'b1; tick(); dst_ready = 1'b0;
    if (c == 2'd2) begin
      tick();
      rsp_valid = 1'b1; rsp_hit = hit; tick(); rsp_valid = 1'b0;
      if (!hit) begin
        for (int i = 0; i < stall; i++) tick();
        dst_ready = 1'b1; tick(); dst_ready = 1'b0;
      end
    end
    tick();
  endtask

  function automatic logic [31:0] mk_addr(input int sel, input int hx, input int hy);
    return (32'(hy) << 18) | (32'(hx) << 16) | (32'(sel) << 14) | 32'h0000_1a40;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R2 private data goes to the requesting tile
    tag = "R2";
    for (int t = 0; t < 16; t++) begin
      tile_x = t % 4; tile_y = t / 4; tile_rid = (t % 4 + 2 * (t / 4)) % 4;
      run_req(mk_addr(t % 4, 3 - t % 4, t / 4), 2'd0, t % 3, 1'b1);
    end
    // R3 shared data goes to the home bank
    tag = "R3";
    for (int h = 0; h < 16; h++) run_req(mk_addr(h % 4, h % 4, h / 4), 2'd1, 0, 1'b1);
    // R10 reserved class code behaves as shared
    tag = "R10";
    for (int h = 0; h < 4; h++) run_req(mk_addr(1, 3 - h, h), 2'd3, 1, 1'b1);
    // R4, R5, R7 instruction lookups on every tile and selector, all hits
    tag = "R4_R5_R7";
    for (int t = 0; t < 16; t++) begin
      tile_x = t % 4; tile_y = t / 4; tile_rid = (t % 4 + 2 * (t / 4)) % 4;
      for (int s = 0; s < 4; s++) run_req(mk_addr(s, s, 3 - s), 2'd2, 0, 1'b1);
    end
    // R8 misses fall back to the home bank with attempt 1
    tag = "R8";
    for (int t = 0; t < 16; t++) begin
      tile_x = t % 4; tile_y = t / 4; tile_rid = t % 4;
      run_req(mk_addr(t % 4, (t + 1) % 4, (t + 2) % 4), 2'd2, 1, 1'b0);
    end
    // R6 long backpressure on both first and fallback sends
    tag = "R6";
    tile_x = 3; tile_y = 3; tile_rid = 1;
    run_req(mk_addr(2, 0, 1), 2'd2, 5, 1'b0);
    run_req(mk_addr(0, 2, 2), 2'd1, 6, 1'b1);
    // R9 responses while idle are ignored
    tag = "R9";
    for (int i = 0; i < 4; i++) begin
      rsp_valid = 1'b1; rsp_hit = i[0]; tick();
      rsp_valid = 1'b0; tick();
    end
    run_req(mk_addr(3, 1, 1), 2'd0, 0, 1'b1);
    tag = "R1";
    repeat (3) tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule